// File: doc/BRIEF.md
# Housekeeping SPI Register Slave

This block lets an external host reach a small bank of byte-wide housekeeping registers over a four-wire serial link. The host pulls the select line low and sends a command byte. It then sends a start address. After that, data bytes flow out of the block (read stream) or into it (write stream), and the register pointer steps forward by one after every byte. Raising the select line closes the transaction.

The bank is a fixed map of 19 byte registers. Most of them hold constant identification values. Register 7 is the only writable one, and its bit 0 drives an external reset output. The serial pins are brought into the system clock domain by multi-flop synchronisers, and the edges of the serial clock are detected there. For that reason the serial clock must run at least four times slower than the system clock. An active-low chip reset returns the bank to its power-up contents.

Top module: `hk_spi_regbank`

## Requirements
- R1: After chip reset, a read stream starting at address 0 returns these bytes for addresses 0 to 18, in order: 00 04 56 10 00 00 00 00 02 01 00 00 00 FF EF FF 03 12 04.
- R2: Bits travel most-significant first. The slave samples `spi_mosi` on each rising `spi_clk`. `spi_miso` changes only after a falling `spi_clk`, so it is stable at the next rising edge. A first byte of 0x40 starts a read stream, and the next byte is the start address.
- R3: Within one select-low period, the register address goes up by one after every data byte, for reads and for writes.
- R4: A first byte of 0x80 starts a write stream. The next byte is the address and each byte after that is data. The byte written to register 7 is stored and reads back unchanged, and `ext_rst_out` follows its bit 0. The new value takes effect only once the eighth bit of the byte has been received.
- R5: If the select line rises before a data byte is complete, that partial byte changes no register.
- R6: Writes to any address other than 7 leave the contents of the register bank unchanged.
- R7: Reads from addresses 19 to 255 return 0x00. The 8-bit address wraps from 255 to 0.
- R8: While `spi_cs_n` is high, `spi_miso` is 0 and the byte framing is cleared. After the next falling edge of the select line, the first complete byte is again taken as a command, even if the previous transaction ended mid-byte.
- R9: Asserting `rst_n` low clears register 7 to 0x00 and drives `ext_rst_out` low.
- R10: A command byte that is neither 0x40 nor 0x80 causes the rest of the transaction to be ignored: nothing is written and `spi_miso` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous chip reset |
| spi_cs_n | input | 1 | Active-low select from the host |
| spi_clk | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| ext_rst_out | output | 1 | External reset, equal to bit 0 of register 7 |

## Verification
The closest coincidence is between a byte commit and the end of the transaction. The eighth rising serial edge of a write byte commits the data and steps the address. A select rise right after that edge must not undo the write, while a select rise one bit earlier must discard the byte. The bench provokes both orders on register 7, ending one write after seven bits and another after eight. It judges them at `ext_rst_out` and by reading register 7 back in a fresh transaction.

// File: rtl/hk_spi_pkg.sv
package hk_spi_pkg;

   localparam int HK_BYTE_W = 8;
   localparam logic [HK_BYTE_W-1:0] HK_CMD_READ  = 8'h40;
   localparam logic [HK_BYTE_W-1:0] HK_CMD_WRITE = 8'h80;

   typedef enum logic [2:0] {
      PH_CMD,
      PH_ADDR_RD,
      PH_ADDR_WR,
      PH_READ,
      PH_WRITE,
      PH_SKIP
   } hk_phase_e;

   // Power-up contents of the housekeeping bank.
   function automatic logic [HK_BYTE_W-1:0] hk_reset_val(input int unsigned idx);
      case (idx)
         1:       return 8'h04;
         2:       return 8'h56;
         3:       return 8'h10;
         8:       return 8'h02;
         9:       return 8'h01;
         13:      return 8'hFF;
         14:      return 8'hEF;
         15:      return 8'hFF;
         16:      return 8'h03;
         17:      return 8'h12;
         18:      return 8'h04;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/hk_sync.sv
module hk_sync #(
   parameter int              W       = 3,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  d,
   output logic [W-1:0]  q
);

   generate
      for (genvar b = 0; b < W; b++) begin : g_bit
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
            else        chain <= {chain[STAGES-2:0], d[b]};
         end
         assign q[b] = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/hk_spi_engine.sv
module hk_spi_engine
   import hk_spi_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_s,
   input  logic              cs_s,
   input  logic              mosi_s,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              miso
);

   localparam int CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

   logic              sck_d;
   logic [CNT_W-1:0]  bit_cnt;
   logic [DATA_W-2:0] in_sh;
   logic [DATA_W-1:0] out_sh;
   logic [ADDR_W-1:0] addr_q;
   hk_phase_e         phase;

   logic              sck_rise, sck_fall, last_bit;
   logic [DATA_W-1:0] byte_in;

   assign sck_rise = sck_s & ~sck_d;
   assign sck_fall = ~sck_s & sck_d;
   assign last_bit = (bit_cnt == LAST_BIT);
   assign byte_in  = {in_sh, mosi_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d   <= 1'b0;
         bit_cnt <= '0;
         in_sh   <= '0;
         out_sh  <= '0;
         addr_q  <= '0;
         phase   <= PH_CMD;
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         sck_d <= sck_s;
         wr_en <= 1'b0;
         if (cs_s) begin
            bit_cnt <= '0;
            out_sh  <= '0;
            phase   <= PH_CMD;
         end else if (sck_rise) begin
            in_sh   <= byte_in[DATA_W-2:0];
            bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
            if (last_bit) begin
               case (phase)
                  PH_CMD: begin
                     if (byte_in == HK_CMD_READ)       phase <= PH_ADDR_RD;
                     else if (byte_in == HK_CMD_WRITE) phase <= PH_ADDR_WR;
                     else                              phase <= PH_SKIP;
                  end
                  PH_ADDR_RD: begin
                     addr_q <= byte_in[ADDR_W-1:0];
                     phase  <= PH_READ;
                  end
                  PH_ADDR_WR: begin
                     addr_q <= byte_in[ADDR_W-1:0];
                     phase  <= PH_WRITE;
                  end
                  PH_READ: addr_q <= addr_q + 1'b1;
                  PH_WRITE: begin
                     wr_en   <= 1'b1;
                     wr_addr <= addr_q;
                     wr_data <= byte_in;
                     addr_q  <= addr_q + 1'b1;
                  end
                  default: ;
               endcase
            end
         end else if (sck_fall) begin
            // Present the next bit while the serial clock is low.
            if (phase != PH_READ)  out_sh <= '0;
            else if (bit_cnt == '0) out_sh <= rd_data;
            else                   out_sh <= {out_sh[DATA_W-2:0], 1'b0};
         end
      end
   end

   assign rd_addr = addr_q;
   assign miso    = out_sh[DATA_W-1];

endmodule

// File: rtl/hk_regfile.sv
module hk_regfile
   import hk_spi_pkg::*;
#(
   parameter int N_REGS   = 19,
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 8,
   parameter int CTRL_IDX = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              ctrl_bit
);

   localparam int IDX_W  = $clog2(N_REGS);
   localparam int SLOTS  = 2 ** IDX_W;

   logic [DATA_W-1:0] ctrl_q;
   logic [DATA_W-1:0] bank [SLOTS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                       ctrl_q <= DATA_W'(hk_reset_val(CTRL_IDX));
      else if (wr_en && wr_addr == ADDR_W'(CTRL_IDX))   ctrl_q <= wr_data;
   end

   generate
      for (genvar g = 0; g < SLOTS; g++) begin : g_slot
         if (g == CTRL_IDX) begin : g_rw
            assign bank[g] = ctrl_q;
         end else if (g < N_REGS) begin : g_ro
            assign bank[g] = DATA_W'(hk_reset_val(g));
         end else begin : g_void
            assign bank[g] = '0;
         end
      end
   endgenerate

   assign rd_data  = (rd_addr < ADDR_W'(N_REGS)) ? bank[rd_addr[IDX_W-1:0]] : '0;
   assign ctrl_bit = ctrl_q[0];

endmodule

// File: rtl/hk_spi_regbank.sv
module hk_spi_regbank
   import hk_spi_pkg::*;
#(
   parameter int N_REGS      = 19,
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 8,
   parameter int CTRL_IDX    = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_cs_n,
   input  logic spi_clk,
   input  logic spi_mosi,
   output logic spi_miso,
   output logic ext_rst_out
);

   generate
      if (DATA_W != HK_BYTE_W) begin : g_bad_width
         $error("DATA_W must equal the command byte width");
      end
      if (ADDR_W > DATA_W) begin : g_bad_addr
         $error("address must fit in one serial byte");
      end
      if (N_REGS > 2 ** ADDR_W) begin : g_bad_regs
         $error("register count exceeds the address space");
      end
      if (CTRL_IDX >= N_REGS) begin : g_bad_ctrl
         $error("control register lies outside the map");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("at least two synchroniser stages are required");
      end
   endgenerate

   logic [2:0]        pins_s;
   logic              cs_s, sck_s, mosi_s;
   logic [ADDR_W-1:0] rd_addr, wr_addr;
   logic [DATA_W-1:0] rd_data, wr_data;
   logic              wr_en;

   hk_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({spi_cs_n, spi_clk, spi_mosi}),
      .q     (pins_s)
   );
   assign {cs_s, sck_s, mosi_s} = pins_s;

   hk_spi_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
      .clk     (clk),
      .rst_n   (rst_n),
      .sck_s   (sck_s),
      .cs_s    (cs_s),
      .mosi_s  (mosi_s),
      .rd_data (rd_data),
      .rd_addr (rd_addr),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .miso    (spi_miso)
   );

   hk_regfile #(.N_REGS(N_REGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_IDX(CTRL_IDX)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .ctrl_bit (ext_rst_out)
   );

endmodule

// File: rtl/hk_spi_regbank_chk.sv
module hk_spi_regbank_chk #(
   parameter int ADDR_W   = 8,
   parameter int CTRL_IDX = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_s,
   input logic              spi_miso,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              ext_rst_out
);

   // R8: a deselected slave drives a quiet data line
   p_quiet_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> !spi_miso);

   // R5: a register write only follows a selected cycle
   p_write_selected_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !$past(cs_s));

   // R4: the external reset moves only after a write to the control register
   p_ctrl_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr == ADDR_W'(CTRL_IDX)) |=> $stable(ext_rst_out));

   // R3: one write strobe per completed byte
   p_single_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   // R9: chip reset holds the external reset low
   always @(negedge clk) begin
      if (rst_n === 1'b0) begin
         p_reset_clear_r9: assert (ext_rst_out == 1'b0);
      end
   end

endmodule

bind hk_spi_regbank hk_spi_regbank_chk #(.ADDR_W(ADDR_W), .CTRL_IDX(CTRL_IDX)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cs_s        (cs_s),
   .spi_miso    (spi_miso),
   .wr_en       (wr_en),
   .wr_addr     (wr_addr),
   .ext_rst_out (ext_rst_out)
);

// File: tb/test_hk_spi_regbank.sv
module test_hk_spi_regbank;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
   logic miso, ext_rst;
   int   n_run = 0, n_fail = 0;
   bit   done = 1'b0;

   always #10 clk = ~clk;

   hk_spi_regbank i_hk_spi_regbank (
      .clk (clk), .rst_n (rst_n), .spi_cs_n (cs_n), .spi_clk (sck),
      .spi_mosi (mosi), .spi_miso (miso), .ext_rst_out (ext_rst)
   );

   // Expected power-up map, addresses 0..18
   localparam logic [7:0] EXP_MAP [19] = '{
      8'h00, 8'h04, 8'h56, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00, 8'h02, 8'h01,
      8'h00, 8'h00, 8'h00, 8'hFF, 8'hEF, 8'hFF, 8'h03, 8'h12, 8'h04 };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic sel;
      cs_n = 1'b0; sck = 1'b0; mosi = 1'b0;
      #400;
   endtask

   task automatic desel;
      sck = 1'b0; mosi = 1'b0; cs_n = 1'b1;
      #400;
   endtask

   // Shift out the top n bits of tx, capture miso before each rising edge.
   task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
      rx = '0;
      for (int i = 7; i > 7 - n; i--) begin
         sck = 1'b0; mosi = tx[i];
         #190 rx[i] = miso;
         #10  sck = 1'b1;
         #200;
      end
      sck = 1'b0;
   endtask

   task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
      bits(tx, 8, rx);
   endtask

   task automatic rd1(input logic [7:0] addr, output logic [7:0] val);
      logic [7:0] junk;
      sel; xbyte(8'h40, junk); xbyte(addr, junk); xbyte(8'h00, val); desel;
   endtask

   task automatic wr1(input logic [7:0] addr, input logic [7:0] val);
      logic [7:0] junk;
      sel; xbyte(8'h80, junk); xbyte(addr, junk); xbyte(val, junk); desel;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: got 0x00 expected 0x01");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] r, junk;
      #105;
      check("R9 ext_rst in reset", {7'd0, ext_rst}, 8'h00);
      check("R8 miso idle in reset", {7'd0, miso}, 8'h00);
      rst_n = 1'b1;
      #400;

      // R1 R3: stream the whole map from address 0 using the table
      sel; xbyte(8'h40, junk); xbyte(8'h00, junk);
      for (int k = 0; k < 19; k++) begin
         xbyte(8'h00, r);
         check($sformatf("R1 R3 map addr %0d", k), r, EXP_MAP[k]);
      end
      desel;
      check("R8 miso after deselect", {7'd0, miso}, 8'h00);

      // R2: single read of the identification byte
      rd1(8'h03, r); check("R2 read addr 3", r, 8'h10);

      // R7: past the end of the map
      sel; xbyte(8'h40, junk); xbyte(8'd17, junk);
      xbyte(8'h00, r); check("R7 addr 17", r, 8'h12);
      xbyte(8'h00, r); check("R7 addr 18", r, 8'h04);
      xbyte(8'h00, r); check("R7 addr 19", r, 8'h00);
      xbyte(8'h00, r); check("R7 addr 20", r, 8'h00);
      desel;
      sel; xbyte(8'h40, junk); xbyte(8'hFF, junk);
      xbyte(8'h00, r); check("R7 addr 255", r, 8'h00);
      xbyte(8'h00, r); check("R7 wrap to 0", r, 8'h00);
      xbyte(8'h00, r); check("R7 wrap to 1", r, 8'h04);
      desel;

      // R5: seven bits of a byte then deselect
      sel; xbyte(8'h80, junk); xbyte(8'h07, junk); bits(8'hFF, 7, junk); desel;
      check("R5 partial byte ext_rst", {7'd0, ext_rst}, 8'h00);
      rd1(8'h07, r); check("R5 partial byte reg7", r, 8'h00);

      // R4: a full byte commits, even with deselect right after it
      sel; xbyte(8'h80, junk); xbyte(8'h07, junk); bits(8'h01, 7, junk);
      check("R4 not before eighth bit", {7'd0, ext_rst}, 8'h00);
      bits(8'h01 << 7, 1, junk);
      #100;
      check("R4 set after eighth bit", {7'd0, ext_rst}, 8'h01);
      desel;
      rd1(8'h07, r); check("R4 readback 0x01", r, 8'h01);
      wr1(8'h07, 8'h00);
      check("R4 release", {7'd0, ext_rst}, 8'h00);
      wr1(8'h07, 8'hA5);
      rd1(8'h07, r); check("R4 readback 0xA5", r, 8'hA5);
      check("R4 bit0 drives output", {7'd0, ext_rst}, 8'h01);
      wr1(8'h07, 8'h00);

      // R6 R3: write stream crossing read-only and control registers
      sel; xbyte(8'h80, junk); xbyte(8'h06, junk);
      xbyte(8'h55, junk); xbyte(8'h01, junk); xbyte(8'h77, junk); desel;
      check("R3 write stream reached reg7", {7'd0, ext_rst}, 8'h01);
      sel; xbyte(8'h40, junk); xbyte(8'h06, junk);
      xbyte(8'h00, r); check("R6 reg6 unchanged", r, 8'h00);
      xbyte(8'h00, r); check("R3 reg7 from stream", r, 8'h01);
      xbyte(8'h00, r); check("R6 reg8 unchanged", r, 8'h02);
      desel;
      wr1(8'h03, 8'hAA);
      rd1(8'h03, r); check("R6 reg3 unchanged", r, 8'h10);

      // R10: unknown command ignored
      wr1(8'h07, 8'h00);
      sel; xbyte(8'h00, junk); xbyte(8'h07, junk); xbyte(8'h01, r); desel;
      check("R10 no write", {7'd0, ext_rst}, 8'h00);
      check("R10 miso quiet", r, 8'h00);

      // R8: abort mid command, new transaction framed afresh
      sel; bits(8'hF0, 4, junk); desel;
      rd1(8'h02, r); check("R8 reframe after abort", r, 8'h56);

      // R9: chip reset clears the control register
      wr1(8'h07, 8'h01);
      check("R9 precondition set", {7'd0, ext_rst}, 8'h01);
      rst_n = 1'b0; #100;
      check("R9 ext_rst cleared", {7'd0, ext_rst}, 8'h00);
      rst_n = 1'b1; #200;
      rd1(8'h07, r); check("R9 reg7 cleared", r, 8'h00);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule